// File: doc/BRIEF.md
# Scrolling Message Column Address Sequencer

This block produces the address of every column of a dot-matrix display so that a message held in a column-organised memory moves from right to left. A window-start register holds the first message column that is visible. At the start of each scan a column pointer copies the window start, and it then steps once for every column shown. After a chosen number of complete scans the window start moves on by one column, so each scan shows the message shifted by one column.

Each memory byte describes one display column. The low seven bits are the row dots and the top bit marks the end of the message. When a column fetch returns the marker, the window start goes back to zero and the message starts again. Two select inputs form the top address bits and pick one of four message regions. A pause input stops the scrolling while the scan carries on.

Top module: `scroll_addr_seq`

## Requirements
- R1: After a synchronous active-low reset, the window start and the column pointer are both zero, so `mem_addr` equals `{msg_sel, 11'd0}`.
- R2: `mem_addr[12:11]` follows `msg_sel` and `mem_addr[10:0]` is the column pointer.
- R3: A `load_req` pulse copies the window start into the column pointer at the next rising edge. Load wins over `col_step` in the same cycle.
- R4: Each `col_step` pulse without `load_req` adds one to the column pointer. The pointer wraps from 2047 to 0 inside the selected region.
- R5: The window start moves on by one after every N `scan_done` pulses, where `rate_sel` 0, 1, 2, 3 gives N = 2, 4, 8, 16.
- R6: While `pause` is high, `scan_done` pulses are ignored: the window start does not move and the scan divider keeps its count.
- R7: A `col_step` cycle in which `fetch_data[7]` is 1 clears the window start to zero. This clear wins over pause and over an advance in the same cycle.
- R8: `row_dots` equals `fetch_data[6:0]` when `fetch_data[7]` is 0, and is all zero when `fetch_data[7]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| col_step | input | 1 | One-cycle pulse: the column pointer moves to the next column |
| scan_done | input | 1 | One-cycle pulse: one complete scan has finished |
| load_req | input | 1 | One-cycle pulse: copy the window start into the column pointer |
| fetch_data | input | 8 | Byte read at `mem_addr`: bit 7 is the end marker, bits 6..0 are the dots |
| msg_sel | input | 2 | Message region select |
| rate_sel | input | 2 | Scans per scroll step: 2, 4, 8 or 16 |
| pause | input | 1 | Holds the window start and the scan divider |
| mem_addr | output | 13 | Column address: message select in the top bits, column in the low bits |
| row_dots | output | 7 | Row dots of the current column, blanked on the end marker |

## Verification
The bench targets the edges of the scan divider at every rate. It checks that the window start is unchanged after N−1 scans and has moved by one after the Nth. A divider that is off by one would scroll one scan too early or too late.

Other checks:
- Load and step arrive in the same cycle. A wrong priority leaves the pointer one column past the window start.
- The end marker is fetched while paused. A design that lets pause mask the clear would never restart the message.
- The column pointer crosses 2047. A pointer that carries into the select bits would leak into the next message region.
- The end-marker byte is shown. A design that does not blank it would light its dots on the display.

// File: rtl/scroll_pkg.sv
// Package: shared widths for the scrolling address sequencer.
// Assumes one memory byte per display column.
package scroll_pkg;
    localparam int COL_W   = 11;           // column address bits per message
    localparam int SEL_W   = 2;            // message select bits
    localparam int DATA_W  = 8;            // fetched byte width
    localparam int DOT_W   = DATA_W - 1;   // row dots per column
    localparam int RATE_W  = 2;            // scroll rate select width
    localparam int DIV_W   = 1 << RATE_W;  // divider count width (max N = 2**DIV_W)
    localparam int ADDR_W  = COL_W + SEL_W;
endpackage

// File: rtl/scan_divider.sv
// Module: scan_divider
// Counts completed scans and gives a one-cycle tick on the Nth,
// where N = 2 << rate_sel. While pause is high the count holds.
// Assumes scan_done is a single-cycle pulse.
module scan_divider #(
    parameter int RATE_W = scroll_pkg::RATE_W,
    parameter int DIV_W  = scroll_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_done,
    input  logic              pause,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              base_tick
);
    localparam logic [DIV_W:0] TWO = (DIV_W+1)'(2);
    localparam logic [DIV_W:0] ONE = (DIV_W+1)'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W:0]   limit;
    logic             at_limit;
    logic             count_en;

    // Terminal count for the selected rate, and the last-scan flag.
    always_comb begin
        limit    = (TWO << rate_sel) - ONE;
        at_limit = ({1'b0, cnt_q} >= limit);
        count_en = scan_done && !pause;
    end

    assign base_tick = count_en && at_limit;

    // Scan counter: wraps on the terminal count and holds while paused.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (count_en)
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
    end

    p_div_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_done || pause) |=> $stable(cnt_q));
endmodule

// File: rtl/base_counter.sv
// Module: base_counter
// Holds the first visible column of the window. A clear returns it
// to zero; otherwise an advance adds one, wrapping at the width.
// Assumes the advance is already gated by pause upstream.
module base_counter #(
    parameter int COL_W = scroll_pkg::COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             clear,
    output logic [COL_W-1:0] base_col
);
    // Window start register; clear has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_col <= '0;
        else if (clear)
            base_col <= '0;
        else if (advance)
            base_col <= base_col + 1'b1;
    end

    p_base_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (base_col == '0));
    p_base_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(base_col));
endmodule

// File: rtl/main_counter.sv
// Module: main_counter
// Column pointer that is loadable from the window start and steps
// once per shown column. A load lands at the next edge and beats a step.
// Assumes load and step are single-cycle pulses.
module main_counter #(
    parameter int COL_W = scroll_pkg::COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [COL_W-1:0] base_in,
    output logic [COL_W-1:0] col
);
    // Pointer register: load first, then step, with modulo wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col <= '0;
        else if (load)
            col <= base_in;
        else if (step)
            col <= col + 1'b1;
    end

    p_main_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (col == $past(base_in)));
    p_main_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (col == $past(col) + 1'b1));
endmodule

// File: rtl/scroll_addr_seq.sv
// Module: scroll_addr_seq (top)
// Builds the column address for a right-to-left scrolling display.
// It chains the scan divider, the window-start counter and the column
// pointer, detects the end marker on fetched bytes and blanks that byte.
// Assumes fetch_data is the byte at mem_addr in the cycle of col_step,
// and that the scan source issues the scroll step before the load.
module scroll_addr_seq #(
    parameter int COL_W  = scroll_pkg::COL_W,
    parameter int SEL_W  = scroll_pkg::SEL_W,
    parameter int DATA_W = scroll_pkg::DATA_W,
    parameter int RATE_W = scroll_pkg::RATE_W,
    parameter int DIV_W  = scroll_pkg::DIV_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    col_step,
    input  logic                    scan_done,
    input  logic                    load_req,
    input  logic [DATA_W-1:0]       fetch_data,
    input  logic [SEL_W-1:0]        msg_sel,
    input  logic [RATE_W-1:0]       rate_sel,
    input  logic                    pause,
    output logic [COL_W+SEL_W-1:0]  mem_addr,
    output logic [DATA_W-2:0]       row_dots
);
    localparam int DOT_W = DATA_W - 1;

    logic             tick;
    logic             end_mark;
    logic [COL_W-1:0] base_col;
    logic [COL_W-1:0] ptr_col;

    // End marker only counts on a column that is actually shown.
    assign end_mark = col_step && fetch_data[DATA_W-1];

    scan_divider #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_done (scan_done),
        .pause     (pause),
        .rate_sel  (rate_sel),
        .base_tick (tick)
    );

    base_counter #(.COL_W(COL_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (tick),
        .clear    (end_mark),
        .base_col (base_col)
    );

    main_counter #(.COL_W(COL_W)) u_main (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_req),
        .step    (col_step),
        .base_in (base_col),
        .col     (ptr_col)
    );

    // Address and row data: region select on top, marker byte blanked.
    always_comb begin
        mem_addr = {msg_sel, ptr_col};
        row_dots = fetch_data[DATA_W-1] ? '0 : fetch_data[DOT_W-1:0];
    end
endmodule

// File: tb/tb_scroll_addr_seq.sv
// Directed bench for scroll_addr_seq: inputs change on the falling edge,
// results are sampled on the falling edge after the rising edge that acts.
module tb_scroll_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        col_step, scan_done, load_req, pause;
    logic [7:0]  fetch_data;
    logic [1:0]  msg_sel, rate_sel;
    logic [12:0] mem_addr;
    logic [6:0]  row_dots;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    scroll_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .col_step(col_step), .scan_done(scan_done),
        .load_req(load_req), .fetch_data(fetch_data), .msg_sel(msg_sel),
        .rate_sel(rate_sel), .pause(pause), .mem_addr(mem_addr), .row_dots(row_dots)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; col_step = 0; scan_done = 0; load_req = 0; pause = 0;
        fetch_data = 8'h00; msg_sel = 2'b00; rate_sel = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_col();
        col_step = 1'b1; @(negedge clk); col_step = 1'b0;
    endtask
    task automatic pulse_scan();
        scan_done = 1'b1; @(negedge clk); scan_done = 1'b0;
    endtask
    task automatic pulse_load();
        load_req = 1'b1; @(negedge clk); load_req = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset address", mem_addr, 0);
        fetch_data = 8'h2A; #1;
        check("R8 dots pass-through", row_dots, 7'h2A);
    endtask

    task automatic t_select();
        do_reset();
        msg_sel = 2'b10; #1;
        check("R2 select 2", mem_addr, 13'h1000);
        msg_sel = 2'b01; #1;
        check("R2 select 1", mem_addr, 13'h0800);
    endtask

    task automatic t_step_load();
        do_reset();
        for (int i = 0; i < 5; i++) pulse_col();
        check("R4 five steps", mem_addr, 5);
        pulse_load();
        check("R3 load window start", mem_addr, 0);
        for (int i = 0; i < 3; i++) pulse_col();
        col_step = 1'b1; load_req = 1'b1; @(negedge clk);
        col_step = 1'b0; load_req = 1'b0;
        check("R3 load beats step", mem_addr, 0);
    endtask

    task automatic t_rates();
        for (int r = 0; r < 4; r++) begin
            do_reset();
            rate_sel = r[1:0];
            for (int k = 0; k < (2 << r) - 1; k++) pulse_scan();
            pulse_load();
            check($sformatf("R5 rate %0d before Nth scan", r), mem_addr, 0);
            pulse_scan();
            pulse_load();
            check($sformatf("R5 rate %0d after Nth scan", r), mem_addr, 1);
        end
    endtask

    task automatic t_pause();
        do_reset();
        pulse_scan();           // divider now at 1 of 2
        pause = 1'b1;
        for (int k = 0; k < 5; k++) pulse_scan();
        pulse_load();
        check("R6 paused window start", mem_addr, 0);
        pause = 1'b0;
        pulse_scan();           // count was held, so this is the 2nd
        pulse_load();
        check("R6 divider held while paused", mem_addr, 1);
    endtask

    task automatic t_marker();
        do_reset();
        for (int k = 0; k < 6; k++) pulse_scan();
        pulse_load();
        check("R5 window start three", mem_addr, 3);
        fetch_data = 8'hFF; #1;
        check("R8 marker blanked", row_dots, 0);
        pause = 1'b1;
        pulse_col();
        fetch_data = 8'h00; pause = 1'b0;
        check("R4 step on marker column", mem_addr, 4);
        pulse_load();
        check("R7 marker restarts message", mem_addr, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        msg_sel = 2'b11;
        for (int i = 0; i < 2047; i++) pulse_col();
        check("R4 last column", mem_addr, 13'h1FFF);
        pulse_col();
        check("R4 wrap stays in region", mem_addr, 13'h1800);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_select();
        t_step_load();
        t_rates();
        t_pause();
        t_marker();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule